// File: doc/BRIEF.md
# SPI Flash Command Decoder

This block sits behind the serial pins of a flash device and turns a mode-0 SPI frame into one parsed command. It runs on the system clock and oversamples the serial clock and the active-low chip select, which must already be synchronous to that clock. While the select is low it takes one bit per serial-clock rising edge, most significant bit first. The first byte is the opcode. The opcode fixes how many address, dummy and data bytes follow.

Read-type commands stream, so the block reports them as soon as their header (opcode, address and any dummy byte) is complete, and then ignores the rest of the frame. Write-type commands commit only when the select returns high exactly on the byte boundary after their last expected byte. A select rise anywhere else throws the frame away and pulses an abort flag. Erase commands report their address with the bits below the erase granule cleared. The parsed opcode, address and first data byte stay on the outputs until the next strobe.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, cmd_valid, cmd_stream and cmd_abort are 0, and cmd_opcode, cmd_addr and cmd_data are all zero.
- R2: A frame starts on a falling edge of ce_n. While ce_n is low, one bit of mosi is taken on each rising edge of sck. Bytes are assembled MSB first. The first byte is the opcode, and the address bytes follow with the most significant byte first.
- R3: The write-type opcodes and their trailing byte counts (address + data) are as follows. 20h, 52h and D8h take 3+0. 02h takes 3+1. ADh takes 3+2. 01h takes 0+1. 06h, 04h, 50h, 70h, 80h, 60h and C7h take 0+0. Such a command pulses cmd_valid for one cycle with cmd_stream=0, in the cycle after the system clock first sees ce_n high, but only when exactly 8*(1+address+data) bits were taken.
- R4: The read-type opcodes pulse cmd_valid for one cycle with cmd_stream=1 in the cycle after the last header bit is taken, while ce_n is still low. 03h, 90h and ABh have 3 address bytes. 0Bh has 3 address bytes plus 1 dummy byte. 05h and 9Fh have no address.
- R5: If ce_n rises before a known command's header (read) or full byte count (write) is complete, cmd_abort pulses for one cycle and cmd_valid stays 0. This includes a frame with fewer than 8 bits.
- R6: If a write-type frame receives any bit after its last expected bit, the command is discarded: cmd_abort pulses at the ce_n rise and cmd_valid stays 0.
- R7: A frame whose opcode byte is not in R3 or R4 gives neither cmd_valid nor cmd_abort, whatever follows it.
- R8: On a strobe, cmd_addr has bits [11:0] cleared for 20h, bits [14:0] cleared for 52h and bits [15:0] cleared for D8h. Other commands report the address bytes unchanged.
- R9: cmd_data holds the first data byte for 02h, ADh and 01h, and 0 for every other command. cmd_addr is 0 for commands without address bytes. cmd_opcode, cmd_addr and cmd_data change only in a cycle where cmd_valid is 1.
- R10: A read-type frame that keeps clocking after its header produces no further strobe and no abort when ce_n finally rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, mode 0, synchronous to clk |
| ce_n | input | 1 | Active-low chip select, synchronous to clk |
| mosi | input | 1 | Serial data in |
| cmd_valid | output | 1 | One-cycle strobe for a parsed command |
| cmd_stream | output | 1 | With cmd_valid: 1 for a read-type command reported mid-frame |
| cmd_abort | output | 1 | One-cycle strobe for a discarded frame |
| cmd_opcode | output | 8 | Opcode of the last strobed command |
| cmd_addr | output | 24 | Address of the last strobed command, erase-masked |
| cmd_data | output | 8 | First data byte of the last strobed command |

## Verification
The assertions assume the pins are already synchronous to clk. They also assume that sck holds each level for at least one clk cycle and that ce_n never changes in the same cycle as an sck rising edge. The commit and abort checks also take for granted that ce_n, once it rises, stays high for at least two cycles. The bench meets all of this by construction. Each sck phase lasts four clk cycles, ce_n changes only while sck has been low for several cycles, and frames are separated by several idle cycles. Random frames mix known and unknown opcodes with exact, short and overlong bit counts.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;

    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_FAST_READ = 8'h0B;
    localparam logic [7:0] OP_ERASE_4K  = 8'h20;
    localparam logic [7:0] OP_ERASE_32K = 8'h52;
    localparam logic [7:0] OP_ERASE_64K = 8'hD8;
    localparam logic [7:0] OP_ERASE_A   = 8'h60;
    localparam logic [7:0] OP_ERASE_B   = 8'hC7;
    localparam logic [7:0] OP_PROG_BYTE = 8'h02;
    localparam logic [7:0] OP_PROG_AUTO = 8'hAD;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_EN   = 8'h50;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_WR_DIS    = 8'h04;
    localparam logic [7:0] OP_ID_A      = 8'h90;
    localparam logic [7:0] OP_ID_B      = 8'hAB;
    localparam logic [7:0] OP_ID_JEDEC  = 8'h9F;
    localparam logic [7:0] OP_BSY_ON    = 8'h70;
    localparam logic [7:0] OP_BSY_OFF   = 8'h80;

    // lowest kept address bit for the three erase granules
    localparam int LSB_4K  = 12;
    localparam int LSB_32K = 15;
    localparam int LSB_64K = 16;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA,
        ST_WAIT_END, ST_OVERRUN, ST_STREAM, ST_DISCARD
    } dec_state_e;

    typedef struct packed {
        logic       known;
        logic       stream;
        logic       has_addr;
        logic       has_dummy;
        logic [1:0] n_data;
    } op_info_t;

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r = '0;
        r.known = 1'b1;
        case (op)
            OP_READ, OP_ID_A, OP_ID_B: begin r.stream = 1'b1; r.has_addr = 1'b1; end
            OP_FAST_READ: begin r.stream = 1'b1; r.has_addr = 1'b1; r.has_dummy = 1'b1; end
            OP_STAT_RD, OP_ID_JEDEC: r.stream = 1'b1;
            OP_ERASE_4K, OP_ERASE_32K, OP_ERASE_64K: r.has_addr = 1'b1;
            OP_PROG_BYTE: begin r.has_addr = 1'b1; r.n_data = 2'd1; end
            OP_PROG_AUTO: begin r.has_addr = 1'b1; r.n_data = 2'd2; end
            OP_STAT_WR: r.n_data = 2'd1;
            OP_STAT_EN, OP_WR_EN, OP_WR_DIS, OP_BSY_ON, OP_BSY_OFF,
            OP_ERASE_A, OP_ERASE_B: r.n_data = 2'd0;
            default: r.known = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_edges.sv
module spi_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ce_n,
    output logic sck_rise,
    output logic ce_fall,
    output logic ce_rise
);
    typedef struct packed {
        logic sck;
        logic ce_n;
    } pins_t;

    pins_t q, d;

    always_comb begin
        d.sck  = sck;
        d.ce_n = ce_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sck  <= 1'b0;
            q.ce_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = sck & ~q.sck;
    assign ce_fall  = ~ce_n & q.ce_n;
    assign ce_rise  = ce_n & ~q.ce_n;
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            din,
    output logic            word_done,
    output logic [BITS-1:0] word_val
);
    localparam int CW = $clog2(BITS);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [BITS-1:0] sr;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
        end else if (shift_en) begin
            d.sr  = {q.sr[BITS-2:0], din};
            d.cnt = (q.cnt == CW'(BITS - 1)) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_done = shift_en & ~clr & (q.cnt == CW'(BITS - 1));
    assign word_val  = {q.sr[BITS-2:0], din};
endmodule

// File: rtl/spi_opcode_classifier.sv
module spi_opcode_classifier
    import spi_dec_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);
    always_comb info = classify(opcode);
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_dec_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck,
    input  logic                  ce_n,
    input  logic                  mosi,
    output logic                  cmd_valid,
    output logic                  cmd_stream,
    output logic                  cmd_abort,
    output logic [7:0]            cmd_opcode,
    output logic [8*ADDR_BYTES-1:0] cmd_addr,
    output logic [7:0]            cmd_data
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 2);

    logic       sck_rise, ce_fall, ce_rise;
    logic       byte_done;
    logic [7:0] byte_val;
    op_info_t   info_in;

    spi_pin_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .ce_n     (ce_n),
        .sck_rise (sck_rise),
        .ce_fall  (ce_fall),
        .ce_rise  (ce_rise)
    );

    spi_bit_shifter #(.BITS(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ce_n),
        .shift_en  (sck_rise),
        .din       (mosi),
        .word_done (byte_done),
        .word_val  (byte_val)
    );

    spi_opcode_classifier u_class (
        .opcode (byte_val),
        .info   (info_in)
    );

    typedef struct packed {
        dec_state_e        state;
        logic [7:0]        opc;
        op_info_t          info;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              data_seen;
        logic [CNT_W-1:0]  rem;
        logic              o_valid;
        logic              o_stream;
        logic              o_abort;
        logic [7:0]        o_opc;
        logic [ADDR_W-1:0] o_addr;
        logic [7:0]        o_data;
    } dec_t;

    dec_t q, d;

    function automatic logic [ADDR_W-1:0] granule_mask(input logic [7:0] op,
                                                       input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] ones;
        ones = '1;
        case (op)
            OP_ERASE_4K:  return a & (ones << LSB_4K);
            OP_ERASE_32K: return a & (ones << LSB_32K);
            OP_ERASE_64K: return a & (ones << LSB_64K);
            default:      return a;
        endcase
    endfunction

    always_comb begin
        logic emit, emit_stream, drop;
        d           = q;
        d.o_valid   = 1'b0;
        d.o_abort   = 1'b0;
        emit        = 1'b0;
        emit_stream = 1'b0;
        drop        = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (ce_fall) begin
                    d.state     = ST_OPC;
                    d.opc       = '0;
                    d.addr      = '0;
                    d.data      = '0;
                    d.data_seen = 1'b0;
                end
            end
            ST_OPC: begin
                if (ce_rise) begin
                    drop = 1'b1;
                end else if (byte_done) begin
                    d.opc  = byte_val;
                    d.info = info_in;
                    if (!info_in.known) begin
                        d.state = ST_DISCARD;
                    end else if (info_in.has_addr) begin
                        d.state = ST_ADDR;
                        d.rem   = CNT_W'(ADDR_BYTES - 1);
                    end else if (info_in.stream) begin
                        emit = 1'b1; emit_stream = 1'b1;
                        d.state = ST_STREAM;
                    end else if (info_in.n_data != 2'd0) begin
                        d.state = ST_DATA;
                        d.rem   = CNT_W'(info_in.n_data - 2'd1);
                    end else begin
                        d.state = ST_WAIT_END;
                    end
                end
            end
            ST_ADDR: begin
                if (ce_rise) begin
                    drop = 1'b1;
                end else if (byte_done) begin
                    d.addr = {q.addr[ADDR_W-9:0], byte_val};
                    if (q.rem != '0) begin
                        d.rem = q.rem - 1'b1;
                    end else if (q.info.has_dummy) begin
                        d.state = ST_DUMMY;
                    end else if (q.info.stream) begin
                        emit = 1'b1; emit_stream = 1'b1;
                        d.state = ST_STREAM;
                    end else if (q.info.n_data != 2'd0) begin
                        d.state = ST_DATA;
                        d.rem   = CNT_W'(q.info.n_data - 2'd1);
                    end else begin
                        d.state = ST_WAIT_END;
                    end
                end
            end
            ST_DUMMY: begin
                if (ce_rise) begin
                    drop = 1'b1;
                end else if (byte_done) begin
                    emit = 1'b1; emit_stream = 1'b1;
                    d.state = ST_STREAM;
                end
            end
            ST_DATA: begin
                if (ce_rise) begin
                    drop = 1'b1;
                end else if (byte_done) begin
                    if (!q.data_seen) begin
                        d.data      = byte_val;
                        d.data_seen = 1'b1;
                    end
                    if (q.rem == '0) d.state = ST_WAIT_END;
                    else             d.rem   = q.rem - 1'b1;
                end
            end
            ST_WAIT_END: begin
                if (ce_rise) begin
                    emit    = 1'b1;
                    d.state = ST_IDLE;
                end else if (sck_rise) begin
                    d.state = ST_OVERRUN;
                end
            end
            ST_OVERRUN: begin
                if (ce_rise) drop = 1'b1;
            end
            ST_STREAM, ST_DISCARD: begin
                if (ce_rise) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase

        if (drop) begin
            d.o_abort = 1'b1;
            d.state   = ST_IDLE;
        end
        if (emit) begin
            d.o_valid  = 1'b1;
            d.o_stream = emit_stream;
            d.o_opc    = d.opc;
            d.o_addr   = granule_mask(d.opc, d.addr);
            d.o_data   = d.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid  = q.o_valid;
    assign cmd_stream = q.o_stream;
    assign cmd_abort  = q.o_abort;
    assign cmd_opcode = q.o_opc;
    assign cmd_addr   = q.o_addr;
    assign cmd_data   = q.o_data;
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              cmd_valid,
    input logic              cmd_stream,
    input logic              cmd_abort,
    input logic [7:0]        cmd_opcode,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [7:0]        cmd_data
);
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_commit_at_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stream) |-> ($past(ce_n) && !$past(ce_n, 2)));

    p_stream_while_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stream) |-> !$past(ce_n));

    p_abort_at_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |-> ($past(ce_n) && !$past(ce_n, 2)));

    p_abort_excludes_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_abort && cmd_valid));

    p_erase_granule_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |->
            ((cmd_opcode != 8'h20 || cmd_addr[11:0] == '0) &&
             (cmd_opcode != 8'h52 || cmd_addr[14:0] == '0) &&
             (cmd_opcode != 8'hD8 || cmd_addr[15:0] == '0)));

    p_read_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stream) |-> (cmd_data == 8'h00));

    p_fields_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_opcode) && $stable(cmd_addr) && $stable(cmd_data)));
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.ADDR_W(8 * ADDR_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .cmd_valid  (cmd_valid),
    .cmd_stream (cmd_stream),
    .cmd_abort  (cmd_abort),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data)
);

// File: tb/tb_spi_cmd_decoder.sv
`timescale 1ns/100ps
module tb_spi_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        ce_n = 1'b1;
    logic        mosi = 1'b0;
    logic        cmd_valid, cmd_stream, cmd_abort;
    logic [7:0]  cmd_opcode, cmd_data;
    logic [23:0] cmd_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int seen_valid = 0, seen_abort = 0;
    logic [7:0]  cap_op, cap_data;
    logic [23:0] cap_addr;
    logic        cap_stream;

    always #2.5 clk = ~clk;

    spi_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ce_n(ce_n), .mosi(mosi),
        .cmd_valid(cmd_valid), .cmd_stream(cmd_stream), .cmd_abort(cmd_abort),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                seen_valid++;
                cap_op = cmd_opcode; cap_addr = cmd_addr;
                cap_data = cmd_data; cap_stream = cmd_stream;
            end
            if (cmd_abort) seen_abort++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void ref_class(input logic [7:0] op, output bit known,
                                      output bit strm, output int na, output int nd,
                                      output int ndat);
        known = 1; strm = 0; na = 0; nd = 0; ndat = 0;
        case (op)
            8'h03, 8'h90, 8'hAB: begin strm = 1; na = 3; end
            8'h0B: begin strm = 1; na = 3; nd = 1; end
            8'h05, 8'h9F: strm = 1;
            8'h20, 8'h52, 8'hD8: na = 3;
            8'h02: begin na = 3; ndat = 1; end
            8'hAD: begin na = 3; ndat = 2; end
            8'h01: ndat = 1;
            8'h06, 8'h04, 8'h50, 8'h70, 8'h80, 8'h60, 8'hC7: ndat = 0;
            default: known = 0;
        endcase
    endfunction

    function automatic logic [23:0] ref_addr(input logic [7:0] op, input logic [23:0] a);
        case (op)
            8'h20: return {a[23:12], 12'h0};
            8'h52: return {a[23:15], 15'h0};
            8'hD8: return {a[23:16], 16'h0};
            default: return a;
        endcase
    endfunction

    // frame[63:56] is the opcode, later bits follow MSB first
    task automatic run_frame(input logic [63:0] frame, input int nbits);
        bit known, strm;
        int na, nd, ndat, hdr, full, ev, ea;
        logic [7:0]  op, edata;
        logic [23:0] eaddr;
        string tag;
        op = frame[63:56];
        ref_class(op, known, strm, na, nd, ndat);
        hdr  = 8 * (1 + na + nd);
        full = strm ? hdr : 8 * (1 + na + ndat);
        ev = 0; ea = 0;
        if (nbits < 8) begin ea = 1; tag = "R5"; end
        else if (!known) tag = "R7";
        else if (strm) begin
            if (nbits >= hdr) begin ev = 1; tag = (nbits > hdr) ? "R10" : "R4"; end
            else begin ea = 1; tag = "R5"; end
        end else begin
            if (nbits == full) begin ev = 1; tag = "R3"; end
            else if (nbits > full) begin ea = 1; tag = "R6"; end
            else begin ea = 1; tag = "R5"; end
        end
        eaddr = (na > 0) ? ref_addr(op, frame[55:32]) : 24'h0;
        edata = (!strm && ndat > 0) ? ((na > 0) ? frame[31:24] : frame[55:48]) : 8'h0;

        @(negedge clk);
        seen_valid = 0; seen_abort = 0;
        ce_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = frame[63 - i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (6) @(negedge clk);

        check(seen_valid == ev, tag, "valid count", seen_valid, ev);
        check(seen_abort == ea, tag, "abort count", seen_abort, ea);
        if (ev == 1 && seen_valid == 1) begin
            check(cap_op == op, "R2", "opcode", cap_op, op);
            check(cap_stream == strm, strm ? "R4" : "R3", "stream flag", cap_stream, strm);
            check(cap_addr == eaddr, (op == 8'h20 || op == 8'h52 || op == 8'hD8) ? "R8" : "R2",
                  "address", cap_addr, eaddr);
            check(cap_data == edata, "R9", "data", cap_data, edata);
        end
    endtask

    localparam int NK = 21;
    logic [7:0] known_ops [NK] = '{8'h03, 8'h0B, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7,
                                   8'h02, 8'hAD, 8'h05, 8'h50, 8'h01, 8'h06, 8'h04,
                                   8'h90, 8'hAB, 8'h9F, 8'h70, 8'h80, 8'h03, 8'h02};

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] fr;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({cmd_valid, cmd_stream, cmd_abort} == 3'b000, "R1", "strobes", 
              {cmd_valid, cmd_stream, cmd_abort}, 0);
        check({cmd_opcode, cmd_addr, cmd_data} == 40'h0, "R1", "fields", cmd_addr, 0);

        // directed corners
        run_frame({8'h06, 56'h0}, 8);                       // write enable, R3
        run_frame({8'h02, 24'h12_3456, 8'hA5, 24'h0}, 40);  // byte program
        run_frame({8'h20, 24'hAB_CDEF, 32'h0}, 32);         // 4K erase mask, R8
        run_frame({8'h52, 24'hFF_FFFF, 32'h0}, 32);
        run_frame({8'hD8, 24'h7F_FFFF, 32'h0}, 32);
        run_frame({8'hAD, 24'h00_0010, 8'h3C, 8'hC3, 16'h0}, 48);
        run_frame({8'h01, 8'h9C, 48'h0}, 16);               // status write
        run_frame({8'h0B, 24'h01_0203, 8'hFF, 24'h0}, 56);  // dummy then stream
        run_frame({8'h05, 56'hFFFF_FFFF_FFFF_FF}, 40);      // R10 long read
        run_frame({8'h02, 24'h12_3456, 8'hA5, 24'h0}, 41);  // R6 one extra bit
        run_frame({8'h02, 24'h12_3456, 8'hA5, 24'h0}, 39);  // R5 one bit short
        run_frame({8'h06, 56'h0}, 0);                       // bare select pulse
        run_frame({8'h3A, 56'hFFFF_FFFF_FFFF_FF}, 24);      // R7 unknown
        run_frame({8'hC7, 56'h0}, 8);
        run_frame({8'hAB, 24'h00_0001, 32'h0}, 32);

        for (int k = 0; k < 150; k++) begin
            logic [7:0] op;
            int nb;
            op = (($urandom % 4) == 0) ? 8'($urandom) : known_ops[$urandom % NK];
            fr = {op, 24'($urandom), 32'($urandom)};
            if (($urandom % 2) == 0) begin
                bit kn, st; int a, dm, dt;
                ref_class(op, kn, st, a, dm, dt);
                nb = 8 * (1 + a + (st ? dm : dt));
            end else begin
                nb = $urandom % 57;
            end
            run_frame(fr, nb);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule